// File: doc/BRIEF.md
# Strided Chunk Copy Engine

This block moves a block of memory from a source region to a destination region in 16-byte chunks. Each side has its own line pattern. After a programmed number of chunks (the line width), that side's address jumps over a programmed number of unused chunks (the gap) before the next line starts. This lets a sub-rectangle be copied between buffers whose row pitches differ. The engine does no format conversion, tiling or scaling. Every chunk is copied exactly as it was read.

Software writes six word-wide registers through a plain write port and reads them back through a combinational read port. The registers are the two base addresses, the byte total, one dimension word per side, and a control word. Setting the start bit launches the transfer. The engine then issues 128-bit read requests on a valid/ready request channel and takes read data on a valid/ready data channel. Each chunk is parked in a single-entry holding buffer, then offered on a valid/ready write channel.

Back-pressure rules apply to each channel:
- A request or write that is offered stays asserted, with its address and data unchanged, until the matching ready is seen high at a clock edge.
- The engine keeps at most one read in flight.
- The engine asks for a new read only while the holding buffer is empty.

Top module: `stride_copy_dma`

## Requirements
- R1: After reset, the control word reads 0, `irq` is low, and neither `rd_req_valid` nor `wr_valid` is asserted.
- R2: The registers are selected by index: 0 source base, 1 destination base, 2 byte total, 3 source dimensions, 4 destination dimensions, 5 control. Each base register holds a byte address shifted right by 3, so the first read address is the source word times 8, and the first write address is the destination word times 8.
- R3: A dimension word carries the line width in bits 15:0 and the gap in bits 31:16, both counted in 16-byte chunks. Chunk k of the source is read from byte `base*8 + ((k / width)*(width+gap) + k % width)*16`.
- R4: The destination side follows the same formula with its own width and gap, independently of the source side. The line breaks of the two sides need not coincide.
- R5: Exactly total/16 chunks are read and total/16 chunks are written. Skipped gap chunks do not count toward the total.
- R6: The data written for chunk k equals the data returned for source chunk k, and chunks are written in order.
- R7: Writing control with bit 0 = 1 while idle launches a transfer: control bit 0 reads 1 from the next cycle on. When the last chunk is written, bit 0 clears and bit 8 (done) sets.
- R8: `irq` is high for exactly one cycle, in the cycle in which bit 8 first reads 1.
- R9: A launch is rejected if either width is 0 or the total is not a multiple of 16. In that case bits 9 and 8 set at once, bit 0 stays 0, and no memory request is made.
- R10: At most one chunk is held between the ports. A read request is never offered while a write is offered.
- R11: An offered read request, and an offered write with its address and data, stay unchanged until accepted.
- R12: While a transfer runs, writes to registers 0 to 4 and to control are ignored.
- R13: Writing control with bit 0 = 0 while idle clears bits 8 and 9.
- R14: A launch with a total of 0 and nonzero widths completes at once. Bit 8 and `irq` are set, bit 9 stays 0, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 35 | Read byte address |
| rd_data_valid | input | 1 | Read data present |
| rd_data_ready | output | 1 | Engine can take read data |
| rd_data | input | 128 | Read data chunk |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 35 | Write byte address |
| wr_data | output | 128 | Write data chunk |

## Verification
A control write takes effect at the clock edge that samples it. The busy bit, or for a rejected or empty launch the done bit, the error bit and `irq`, is therefore readable just after that edge. Done and `irq` of a normal transfer rise at the edge that accepts the last write. Read data for a request may be returned from the falling edge after its acceptance onward, and the engine does not offer the chunk for writing until the edge after that data is taken. The bench drives and samples only at falling edges. It counts a handshake when it raises a ready against a valid that cannot change before the next rising edge. It checks register reads one time step after the falling edge that follows the write's edge.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int REG_W      = 32;
  localparam int CHUNK_LOG2 = 4;
  localparam int DIM_W      = 16;

  typedef enum logic [2:0] {
    IDX_SRC   = 3'd0,
    IDX_DST   = 3'd1,
    IDX_TOTAL = 3'd2,
    IDX_SDIM  = 3'd3,
    IDX_DDIM  = 3'd4,
    IDX_CTRL  = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic [DIM_W-1:0] gap;
    logic [DIM_W-1:0] width;
  } dim_t;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_DONE = 8;
  localparam int CTRL_ERR  = 9;
endpackage

// File: rtl/scm_regs.sv
module scm_regs
  import scm_pkg::*;
#(
  parameter int CW = REG_W - CHUNK_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             fin,
  output logic             busy,
  output logic             launch,
  output logic             irq,
  output logic [REG_W-1:0] src_base,
  output logic [REG_W-1:0] dst_base,
  output logic [CW-1:0]    chunks,
  output dim_t             sdim,
  output dim_t             ddim
);
  logic [REG_W-1:0] src_q, dst_q, total_q;
  dim_t             sdim_q, ddim_q;
  logic             busy_q, done_q, err_q, irq_q;
  logic             ctrl_wr, go_wr, clr_wr, bad_cfg, empty_cfg;

  assign ctrl_wr   = cfg_we && (cfg_addr == IDX_CTRL) && !busy_q;
  assign go_wr     = ctrl_wr && cfg_wdata[CTRL_GO];
  assign clr_wr    = ctrl_wr && !cfg_wdata[CTRL_GO];
  assign bad_cfg   = (sdim_q.width == '0) || (ddim_q.width == '0) ||
                     (total_q[CHUNK_LOG2-1:0] != '0);
  assign empty_cfg = (total_q[REG_W-1:CHUNK_LOG2] == '0);
  assign launch    = go_wr && !bad_cfg && !empty_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      total_q <= '0;
      sdim_q  <= '0;
      ddim_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we && !busy_q) begin
        case (reg_idx_e'(cfg_addr))
          IDX_SRC:   src_q   <= cfg_wdata;
          IDX_DST:   dst_q   <= cfg_wdata;
          IDX_TOTAL: total_q <= cfg_wdata;
          IDX_SDIM:  sdim_q  <= cfg_wdata;
          IDX_DDIM:  ddim_q  <= cfg_wdata;
          default: ;
        endcase
      end
      if (go_wr) begin
        busy_q <= launch;
        done_q <= !launch;
        err_q  <= bad_cfg;
        irq_q  <= !launch;
      end else if (clr_wr) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (reg_idx_e'(cfg_addr))
      IDX_SRC:   cfg_rdata = src_q;
      IDX_DST:   cfg_rdata = dst_q;
      IDX_TOTAL: cfg_rdata = total_q;
      IDX_SDIM:  cfg_rdata = sdim_q;
      IDX_DDIM:  cfg_rdata = ddim_q;
      IDX_CTRL: begin
        cfg_rdata[CTRL_GO]   = busy_q;
        cfg_rdata[CTRL_DONE] = done_q;
        cfg_rdata[CTRL_ERR]  = err_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  assign busy     = busy_q;
  assign irq      = irq_q;
  assign src_base = src_q;
  assign dst_base = dst_q;
  assign chunks   = total_q[REG_W-1:CHUNK_LOG2];
  assign sdim     = sdim_q;
  assign ddim     = ddim_q;

  // R8: the pulse only ever accompanies a set done bit
  assert_irq_marks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);
  // R8: done never rises without the pulse
  assert_done_rise_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> irq_q);
  // R7: completion only comes from a running transfer
  assert_fin_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> busy_q);
  // R9: an error never coexists with a running transfer
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q);
endmodule

// File: rtl/scm_walker.sv
module scm_walker
  import scm_pkg::*;
#(
  parameter int BASE_W = REG_W,
  parameter int AW     = BASE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BASE_W-1:0] base,
  input  dim_t              dim,
  input  logic              step,
  output logic [AW-1:0]     addr
);
  localparam logic [AW-1:0] CHUNK = AW'(1) << CHUNK_LOG2;

  logic [AW-1:0]    addr_q, skip;
  logic [DIM_W-1:0] pos_q, width_q, gap_q;
  logic             line_end;

  assign line_end = (pos_q == width_q - DIM_W'(1));
  assign skip     = (AW'(gap_q) + AW'(1)) << CHUNK_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pos_q   <= '0;
      width_q <= '0;
      gap_q   <= '0;
    end else if (load) begin
      addr_q  <= {base, 3'b000};
      pos_q   <= '0;
      width_q <= dim.width;
      gap_q   <= dim.gap;
    end else if (step) begin
      if (line_end) begin
        addr_q <= addr_q + skip;
        pos_q  <= '0;
      end else begin
        addr_q <= addr_q + CHUNK;
        pos_q  <= pos_q + DIM_W'(1);
      end
    end
  end

  assign addr = addr_q;

  // R3: the position within a line never reaches the line width
  assert_pos_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q != '0) |-> (pos_q < width_q));
endmodule

// File: rtl/scm_hold.sv
module scm_hold #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         unload,
  output logic         full,
  output logic [W-1:0] dout
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        data_q <= din;
      end else if (unload) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full = full_q;
  assign dout = data_q;

  // R10: a chunk is never written over an occupied entry
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unload |-> full_q);
endmodule

// File: rtl/stride_copy_dma.sv
module stride_copy_dma
  import scm_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int AW     = REG_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              irq,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CW = REG_W - CHUNK_LOG2;

  logic             busy, launch, fin, full;
  logic [REG_W-1:0] src_base, dst_base;
  logic [CW-1:0]    chunks, n_q, rd_cnt_q, wr_cnt_q;
  dim_t             sdim, ddim;
  logic             rd_pend_q, rd_fire, rd_take, wr_fire;

  scm_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fin(fin), .busy(busy),
    .launch(launch), .irq(irq), .src_base(src_base), .dst_base(dst_base),
    .chunks(chunks), .sdim(sdim), .ddim(ddim)
  );

  scm_walker #(.BASE_W(REG_W), .AW(AW)) u_src_walk (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(src_base), .dim(sdim),
    .step(rd_fire), .addr(rd_req_addr)
  );

  scm_walker #(.BASE_W(REG_W), .AW(AW)) u_dst_walk (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(dst_base), .dim(ddim),
    .step(wr_fire), .addr(wr_addr)
  );

  scm_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(rd_take), .din(rd_data),
    .unload(wr_fire), .full(full), .dout(wr_data)
  );

  assign rd_req_valid  = busy && !rd_pend_q && !full && (rd_cnt_q != n_q);
  assign rd_data_ready = rd_pend_q && !full;
  assign wr_valid      = full;
  assign rd_fire       = rd_req_valid && rd_req_ready;
  assign rd_take       = rd_data_valid && rd_data_ready;
  assign wr_fire       = wr_valid && wr_ready;
  assign fin           = wr_fire && ((wr_cnt_q + CW'(1)) == n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q       <= '0;
      rd_cnt_q  <= '0;
      wr_cnt_q  <= '0;
      rd_pend_q <= 1'b0;
    end else if (launch) begin
      n_q       <= chunks;
      rd_cnt_q  <= '0;
      wr_cnt_q  <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      if (rd_fire) begin
        rd_cnt_q  <= rd_cnt_q + CW'(1);
        rd_pend_q <= 1'b1;
      end else if (rd_take) begin
        rd_pend_q <= 1'b0;
      end
      if (wr_fire) wr_cnt_q <= wr_cnt_q + CW'(1);
    end
  end

  // R11: an unaccepted read request holds its address
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R11: an unaccepted write holds address and data
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R10: reads lead writes by at most one chunk
  assert_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_q <= rd_cnt_q) && ((rd_cnt_q - wr_cnt_q) <= CW'(1)));
  // R5: never more reads than the programmed chunk count
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q <= n_q);
endmodule

// File: tb/sim_stride_copy_dma.sv
module sim_stride_copy_dma;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         irq;
  logic         rd_req_valid, rd_data_ready, wr_valid;
  logic         rd_req_ready = 1'b0, rd_data_valid = 1'b0, wr_ready = 1'b0;
  logic [34:0]  rd_req_addr, wr_addr;
  logic [127:0] rd_data = '0, wr_data;

  always #5 clk = ~clk;

  stride_copy_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, errors = 0;
  int e_sw = 1, e_sg = 0, e_dw = 1, e_dg = 0;
  logic [31:0] e_src = '0, e_dst = '0;
  int rd_k = 0, wr_k = 0, irq_cnt = 0, both_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit irq_prev = 0, rsp_pend = 0, rq_wait = 0, wq_wait = 0;
  int rsp_dly = 0;
  logic [34:0] rsp_addr = '0, rq_addr = '0, wq_addr = '0;
  logic [127:0] wq_data = '0;

  function automatic logic [34:0] walk(logic [31:0] base, int w, int g, int k);
    longint off = longint'(k / w) * (w + g) + (k % w);
    return {base, 3'b000} + 35'(off * 16);
  endfunction

  function automatic logic [127:0] pat(logic [34:0] a);
    return {32'hC0DE0000 ^ a[31:0], ~a[31:0], a[31:0] + 32'h1111, 29'd0, a[34:32]};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory-side responder, sink and port monitors, all at falling edges
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        if (irq_prev) chk(0, "R8 pulse longer than one cycle", 2, 1);
      end
      irq_prev = irq;
      if (rd_req_valid && wr_valid) both_cnt++;
      if (rq_wait) chk(rd_req_valid && rd_req_addr == rq_addr, "R11 read hold",
                       {rd_req_valid, rd_req_addr}, {1'b1, rq_addr});
      if (wq_wait) chk(wr_valid && wr_addr == wq_addr && wr_data == wq_data, "R11 write hold",
                       {wr_valid, wr_addr}, {1'b1, wq_addr});
      if (rsp_pend) begin
        if (rsp_dly > 0) begin
          rsp_dly--;
          rd_data_valid = 1'b0;
        end else begin
          rd_data_valid = 1'b1;
          rd_data = pat(rsp_addr);
          if (rd_data_ready) rsp_pend = 0;
        end
      end else rd_data_valid = 1'b0;
      rq_wait = 0;
      if (!rsp_pend && rd_req_valid) begin
        if (lfsr[0]) begin
          rd_req_ready = 1'b1;
          chk(rd_req_addr == walk(e_src, e_sw, e_sg, rd_k), "R2 R3 read address",
              rd_req_addr, walk(e_src, e_sw, e_sg, rd_k));
          rd_k++;
          rsp_pend = 1;
          rsp_addr = rd_req_addr;
          rsp_dly = int'(lfsr[2:1]);
        end else begin
          rd_req_ready = 1'b0;
          rq_wait = 1;
          rq_addr = rd_req_addr;
        end
      end else rd_req_ready = 1'b0;
      wq_wait = 0;
      if (wr_valid) begin
        if (lfsr[3]) begin
          wr_ready = 1'b1;
          chk(wr_addr == walk(e_dst, e_dw, e_dg, wr_k), "R4 write address",
              wr_addr, walk(e_dst, e_dw, e_dg, wr_k));
          chk(wr_data == pat(walk(e_src, e_sw, e_sg, wr_k)), "R6 write data",
              wr_data, pat(walk(e_src, e_sw, e_sg, wr_k)));
          wr_k++;
        end else begin
          wr_ready = 1'b0;
          wq_wait = 1;
          wq_addr = wr_addr;
          wq_data = wr_data;
        end
      end else wr_ready = 1'b0;
    end
  end

  task automatic wr_reg(logic [2:0] idx, logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] idx, output logic [31:0] val);
    cfg_addr = idx;
    #1;
    val = cfg_rdata;
  endtask

  task automatic run_case(logic [31:0] src, logic [31:0] dst, logic [31:0] total,
                          int sw, int sg, int dw, int dg, bit poke);
    logic [31:0] v;
    int base_irq, n, guard;
    bit bad;
    e_src = src; e_dst = dst; e_sw = (sw == 0) ? 1 : sw; e_sg = sg;
    e_dw = (dw == 0) ? 1 : dw; e_dg = dg;
    rd_k = 0; wr_k = 0;
    bad = (sw == 0) || (dw == 0) || (total[3:0] != 0);
    n = bad ? 0 : int'(total >> 4);
    wr_reg(3'd0, src);
    wr_reg(3'd1, dst);
    wr_reg(3'd2, total);
    wr_reg(3'd3, {16'(sg), 16'(sw)});
    wr_reg(3'd4, {16'(dg), 16'(dw)});
    base_irq = irq_cnt;
    wr_reg(3'd5, 32'h1);
    if (n > 0) begin
      rd_reg(3'd5, v);
      if (irq_cnt == base_irq) chk(v[0] == 1'b1, "R7 busy after start", v, 1);
      if (poke) begin
        wr_reg(3'd0, 32'hFFFF0000);
        rd_reg(3'd0, v);
        chk(v == src, "R12 write ignored while busy", v, src);
        wr_reg(3'd5, 32'h0);
      end
    end
    guard = 0;
    while (irq_cnt == base_irq && guard < 5000) begin
      @(negedge clk); #1;
      guard++;
    end
    rd_reg(3'd5, v);
    if (bad) chk(v == 32'h300, "R9 error flags", v, 32'h300);
    else if (n == 0) chk(v == 32'h100, "R14 empty transfer", v, 32'h100);
    else chk(v == 32'h100, "R7 done state", v, 32'h100);
    @(negedge clk); #1;
    chk(irq_cnt == base_irq + 1, "R8 single pulse", 128'(irq_cnt - base_irq), 1);
    chk(rd_k == n && wr_k == n, "R5 chunk counts", {64'(rd_k), 64'(wr_k)}, {64'(n), 64'(n)});
    wr_reg(3'd5, 32'h0);
    rd_reg(3'd5, v);
    chk(v == 32'h0, "R13 clear flags", v, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd_reg(3'd5, v);
    chk(v == 0 && !irq && !rd_req_valid && !wr_valid, "R1 reset state",
        {v, irq, rd_req_valid, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!rd_req_valid && !wr_valid && !irq, "R1 idle after reset",
        {rd_req_valid, wr_valid, irq}, 0);
    for (int sw = 1; sw <= 3; sw++)
      for (int sg = 0; sg <= 2; sg++)
        for (int dw = 1; dw <= 3; dw++)
          for (int dg = 0; dg <= 2; dg++)
            run_case(32'h100 + 32'(sw * 7), 32'h4000 + 32'(dg * 3), 32'd112, sw, sg, dw, dg, 0);
    run_case(32'h1000_0001, 32'h1FFF_FFF0, 32'd16, 1, 5, 2, 1, 0);
    run_case(32'h200, 32'h800, 32'd160, 64, 3, 4, 9, 1);
    run_case(32'h300, 32'h900, 32'd64, 0, 1, 2, 0, 0);
    run_case(32'h300, 32'h900, 32'd64, 2, 1, 0, 0, 0);
    run_case(32'h300, 32'h900, 32'd100, 2, 1, 2, 0, 0);
    run_case(32'h300, 32'h900, 32'd0, 2, 1, 2, 0, 0);
    chk(both_cnt == 0, "R10 read offered during write", 128'(both_cnt), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule